// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Extension

This block is the purely combinational integer datapath of a load-store RISC core. It accepts an operation code, two source operands (called S and T), a 16-bit immediate and a 5-bit shift count. In the same cycle it returns a 32-bit result and a flag that requests an arithmetic-overflow trap. The decoder upstream has already split the instruction word into these fields. This unit chooses how to widen the immediate, which shift count to use, and which functional unit drives the result.

The unit contains one shared adder/subtractor, a bitwise logic unit and a shifter. The shifter can be built either as a staged logarithmic barrel or as a single behavioural shift, selected by a parameter. Only the signed add and subtract operations can raise the trap. In every case the wrapped result is still presented, and the core decides whether to commit it.

Top module: `exec_alu`

## Requirements
- R1: Opcodes 0 (S+T) and 2 (S−T) give the 32-bit wrapped result and raise `ovf_trap_o` exactly when the signed result is not representable in 32 bits.
- R2: Opcodes 1 (S+T) and 3 (S−T) give the same wrapped result as opcodes 0 and 2, and `ovf_trap_o` stays 0.
- R3: Opcodes 8 and 9 add S to the immediate after sign extension to 32 bits (bit 15 copied into bits 31:16). Opcode 8 raises the trap on signed overflow. Opcode 9 never raises it.
- R4: Opcodes 4, 5, 6 and 7 give S AND T, S OR T, S XOR T and NOT(S OR T).
- R5: Opcodes 10, 11 and 12 give S AND, OR and XOR the immediate after zero extension, with bits 31:16 of the extended value equal to 0.
- R6: Opcode 13 places the immediate in result bits 31:16 and forces bits 15:0 to 0.
- R7: Opcodes 14 (left, logical), 15 (right, logical) and 16 (right, arithmetic, sign bit replicated) shift T by `shamt_i`.
- R8: Opcodes 17, 18 and 19 perform the same three shifts of T. The count comes from bits 4:0 of S, and bits 31:5 of S have no effect on the result.
- R9: For addition, overflow means both addends have the same sign and the sum has the other sign. For subtraction, it means S and T differ in sign and the difference differs in sign from S.
- R10: `ovf_trap_o` is 0 for every opcode except 0, 2 and 8. Opcodes 20 to 31 give result 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code (encoding in R1 to R10) |
| src_s_i | input | 32 | First source operand S; also the variable shift count |
| src_t_i | input | 32 | Second source operand T; the value that is shifted |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Constant shift count |
| result_o | output | 32 | Operation result |
| ovf_trap_o | output | 1 | Signed-overflow trap request |

## Verification
The bound checker re-evaluates its properties whenever an input changes:
- The trap flag is compared with a sign-extended wide sum or difference for opcodes 0, 2 and 8.
- The flag must be quiet for every other opcode.
- The upper-immediate layout is checked, as is the zero upper half of the AND-immediate result.
- Unused codes must give zero.

Shift directions, sign fill, and the rule that the high bits of S do not affect a variable shift are shown only by the bench. The bench sweeps every opcode against corner operands and every shift count, and compares each result with its own reference model.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD   = 5'd0,
      OP_ADDU  = 5'd1,
      OP_SUB   = 5'd2,
      OP_SUBU  = 5'd3,
      OP_AND   = 5'd4,
      OP_OR    = 5'd5,
      OP_XOR   = 5'd6,
      OP_NOR   = 5'd7,
      OP_ADDI  = 5'd8,
      OP_ADDIU = 5'd9,
      OP_ANDI  = 5'd10,
      OP_ORI   = 5'd11,
      OP_XORI  = 5'd12,
      OP_LUI   = 5'd13,
      OP_SLL   = 5'd14,
      OP_SRL   = 5'd15,
      OP_SRA   = 5'd16,
      OP_SLLV  = 5'd17,
      OP_SRLV  = 5'd18,
      OP_SRAV  = 5'd19
   } alu_op_e;

   typedef enum logic [1:0] {
      SH_LL = 2'd0,
      SH_RL = 2'd1,
      SH_RA = 2'd2
   } shift_kind_e;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_OR  = 2'd1,
      LG_XOR = 2'd2,
      LG_NOR = 2'd3
   } logic_kind_e;

   typedef enum logic [2:0] {
      RS_ZERO  = 3'd0,
      RS_ARITH = 3'd1,
      RS_LOGIC = 3'd2,
      RS_SHIFT = 3'd3,
      RS_UPPER = 3'd4
   } res_src_e;

endpackage

// File: rtl/imm_extend.sv
module imm_extend #(
   parameter int XLEN  = 32,
   parameter int IMM_W = 16
) (
   input  logic [IMM_W-1:0] imm,
   input  logic             sign_en,
   output logic [XLEN-1:0]  ext
);
   localparam int PAD_W = XLEN - IMM_W;

   logic fill;

   // Fill bit is the immediate's MSB only when sign extension is requested.
   assign fill = sign_en & imm[IMM_W-1];
   assign ext  = {{PAD_W{fill}}, imm};
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic            sub,
   output logic [XLEN-1:0] sum,
   output logic            ovf
);
   localparam int MSB = XLEN - 1;

   logic [XLEN-1:0] b_eff;

   // Subtraction reuses the adder: a + ~b + 1.
   assign b_eff = sub ? ~b : b;
   assign sum   = a + b_eff + {{(XLEN-1){1'b0}}, sub};
   assign ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/logic_unit.sv
module logic_unit #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0]          a,
   input  logic [XLEN-1:0]          b,
   input  alu_pkg::logic_kind_e     kind,
   output logic [XLEN-1:0]          y
);
   import alu_pkg::*;

   always_comb begin
      unique case (kind)
         LG_AND:  y = a & b;
         LG_OR:   y = a | b;
         LG_XOR:  y = a ^ b;
         default: y = ~(a | b);
      endcase
   end
endmodule

// File: rtl/shift_unit.sv
module shift_unit #(
   parameter int XLEN    = 32,
   parameter bit BARREL  = 1'b1,
   localparam int SHAMT_W = $clog2(XLEN)
) (
   input  logic [XLEN-1:0]     val,
   input  logic [SHAMT_W-1:0]  amt,
   input  alu_pkg::shift_kind_e kind,
   output logic [XLEN-1:0]     y
);
   import alu_pkg::*;

   if (BARREL) begin : g_barrel
      // One stage per count bit; stage k moves by 2**k when amt[k] is set.
      logic [XLEN-1:0] stg [SHAMT_W+1];
      assign stg[0] = val;
      for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
         localparam int DIST = 1 << k;
         logic [XLEN-1:0] moved;
         always_comb begin
            case (kind)
               SH_LL:   moved = stg[k] << DIST;
               SH_RA:   moved = $signed(stg[k]) >>> DIST;
               default: moved = stg[k] >> DIST;
            endcase
         end
         assign stg[k+1] = amt[k] ? moved : stg[k];
      end
      assign y = stg[SHAMT_W];
   end else begin : g_flat
      // Single behavioural shift; synthesis chooses the structure.
      always_comb begin
         case (kind)
            SH_LL:   y = val << amt;
            SH_RA:   y = $signed(val) >>> amt;
            default: y = val >> amt;
         endcase
      end
   end
endmodule

// File: rtl/exec_alu.sv
module exec_alu #(
   parameter int XLEN    = 32,
   parameter int IMM_W   = 16,
   parameter bit BARREL  = 1'b1,
   localparam int SHAMT_W = $clog2(XLEN)
) (
   input  logic [4:0]         op_i,
   input  logic [XLEN-1:0]    src_s_i,
   input  logic [XLEN-1:0]    src_t_i,
   input  logic [IMM_W-1:0]   imm_i,
   input  logic [SHAMT_W-1:0] shamt_i,
   output logic [XLEN-1:0]    result_o,
   output logic               ovf_trap_o
);
   import alu_pkg::*;

   localparam int LOW_W = XLEN - IMM_W;

   // Elaboration-time parameter checks
   if (IMM_W >= XLEN) begin : g_bad_imm
      $error("exec_alu: IMM_W must be narrower than XLEN");
   end
   if ((1 << SHAMT_W) != XLEN) begin : g_bad_xlen
      $error("exec_alu: XLEN must be a power of two");
   end

   alu_op_e     op;
   logic        use_imm, imm_signed, do_sub, trap_en, shift_var;
   logic_kind_e lg_kind;
   shift_kind_e sh_kind;
   res_src_e    res_src;

   logic [XLEN-1:0]    imm_ext, operand_b, arith_y, logic_y, shift_y;
   logic [SHAMT_W-1:0] shift_amt;
   logic               arith_ovf;

   assign op = alu_op_e'(op_i);

   // Decode: choose operand source, extension mode, unit controls and trap enable
   always_comb begin
      use_imm    = 1'b0;
      imm_signed = 1'b0;
      do_sub     = 1'b0;
      trap_en    = 1'b0;
      shift_var  = 1'b0;
      lg_kind    = LG_AND;
      sh_kind    = SH_LL;
      res_src    = RS_ZERO;
      case (op)
         OP_ADD:   begin res_src = RS_ARITH; trap_en = 1'b1; end
         OP_ADDU:  begin res_src = RS_ARITH; end
         OP_SUB:   begin res_src = RS_ARITH; do_sub = 1'b1; trap_en = 1'b1; end
         OP_SUBU:  begin res_src = RS_ARITH; do_sub = 1'b1; end
         OP_AND:   begin res_src = RS_LOGIC; lg_kind = LG_AND; end
         OP_OR:    begin res_src = RS_LOGIC; lg_kind = LG_OR;  end
         OP_XOR:   begin res_src = RS_LOGIC; lg_kind = LG_XOR; end
         OP_NOR:   begin res_src = RS_LOGIC; lg_kind = LG_NOR; end
         OP_ADDI:  begin res_src = RS_ARITH; use_imm = 1'b1; imm_signed = 1'b1; trap_en = 1'b1; end
         OP_ADDIU: begin res_src = RS_ARITH; use_imm = 1'b1; imm_signed = 1'b1; end
         OP_ANDI:  begin res_src = RS_LOGIC; use_imm = 1'b1; lg_kind = LG_AND; end
         OP_ORI:   begin res_src = RS_LOGIC; use_imm = 1'b1; lg_kind = LG_OR;  end
         OP_XORI:  begin res_src = RS_LOGIC; use_imm = 1'b1; lg_kind = LG_XOR; end
         OP_LUI:   begin res_src = RS_UPPER; end
         OP_SLL:   begin res_src = RS_SHIFT; sh_kind = SH_LL; end
         OP_SRL:   begin res_src = RS_SHIFT; sh_kind = SH_RL; end
         OP_SRA:   begin res_src = RS_SHIFT; sh_kind = SH_RA; end
         OP_SLLV:  begin res_src = RS_SHIFT; sh_kind = SH_LL; shift_var = 1'b1; end
         OP_SRLV:  begin res_src = RS_SHIFT; sh_kind = SH_RL; shift_var = 1'b1; end
         OP_SRAV:  begin res_src = RS_SHIFT; sh_kind = SH_RA; shift_var = 1'b1; end
         default:  res_src = RS_ZERO;
      endcase
   end

   imm_extend #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ext (
      .imm     (imm_i),
      .sign_en (imm_signed),
      .ext     (imm_ext)
   );

   assign operand_b = use_imm ? imm_ext : src_t_i;
   assign shift_amt = shift_var ? src_s_i[SHAMT_W-1:0] : shamt_i;

   addsub_unit #(.XLEN(XLEN)) u_arith (
      .a   (src_s_i),
      .b   (operand_b),
      .sub (do_sub),
      .sum (arith_y),
      .ovf (arith_ovf)
   );

   logic_unit #(.XLEN(XLEN)) u_logic (
      .a    (src_s_i),
      .b    (operand_b),
      .kind (lg_kind),
      .y    (logic_y)
   );

   shift_unit #(.XLEN(XLEN), .BARREL(BARREL)) u_shift (
      .val  (src_t_i),
      .amt  (shift_amt),
      .kind (sh_kind),
      .y    (shift_y)
   );

   // Result selection
   always_comb begin
      case (res_src)
         RS_ARITH: result_o = arith_y;
         RS_LOGIC: result_o = logic_y;
         RS_SHIFT: result_o = shift_y;
         RS_UPPER: result_o = {imm_i, {LOW_W{1'b0}}};
         default:  result_o = '0;
      endcase
   end

   assign ovf_trap_o = trap_en & arith_ovf;
endmodule

// File: rtl/exec_alu_chk.sv
module exec_alu_chk #(
   parameter int XLEN    = 32,
   parameter int IMM_W   = 16,
   localparam int SHAMT_W = $clog2(XLEN)
) (
   input logic [4:0]         op_i,
   input logic [XLEN-1:0]    src_s_i,
   input logic [XLEN-1:0]    src_t_i,
   input logic [IMM_W-1:0]   imm_i,
   input logic [SHAMT_W-1:0] shamt_i,
   input logic [XLEN-1:0]    result_o,
   input logic               ovf_trap_o
);
   localparam int LOW_W = XLEN - IMM_W;

   logic [XLEN:0]   wide_add, wide_sub, wide_addi;
   logic [XLEN-1:0] sx_imm;

   assign sx_imm    = {{LOW_W{imm_i[IMM_W-1]}}, imm_i};
   assign wide_add  = {src_s_i[XLEN-1], src_s_i} + {src_t_i[XLEN-1], src_t_i};
   assign wide_sub  = {src_s_i[XLEN-1], src_s_i} - {src_t_i[XLEN-1], src_t_i};
   assign wide_addi = {src_s_i[XLEN-1], src_s_i} + {sx_imm[XLEN-1], sx_imm};

   always_comb begin
      // R10
      if (op_i != 5'd0 && op_i != 5'd2 && op_i != 5'd8) begin
         no_overflow_chk: assert (!ovf_trap_o);
      end
      // R9
      if (op_i == 5'd0) begin
         add_ovf_chk: assert (ovf_trap_o == (wide_add[XLEN] != wide_add[XLEN-1]));
      end
      // R1
      if (op_i == 5'd2) begin
         sub_ovf_chk: assert (ovf_trap_o == (wide_sub[XLEN] != wide_sub[XLEN-1]));
      end
      // R3
      if (op_i == 5'd8) begin
         addi_ovf_chk: assert (ovf_trap_o == (wide_addi[XLEN] != wide_addi[XLEN-1]));
      end
      // R6
      if (op_i == 5'd13) begin
         upper_imm_chk: assert (result_o == {imm_i, {LOW_W{1'b0}}});
      end
      // R5
      if (op_i == 5'd10) begin
         andi_upper_zero_chk: assert (result_o[XLEN-1:IMM_W] == '0);
      end
      // R10
      if (op_i >= 5'd20) begin
         unused_zero_chk: assert (result_o == '0);
      end
      // R2
      if (op_i == 5'd1) begin
         unsigned_sum_chk: assert (result_o == wide_add[XLEN-1:0]);
      end
   end
endmodule

bind exec_alu exec_alu_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_exec_alu_chk (
   .op_i       (op_i),
   .src_s_i    (src_s_i),
   .src_t_i    (src_t_i),
   .imm_i      (imm_i),
   .shamt_i    (shamt_i),
   .result_o   (result_o),
   .ovf_trap_o (ovf_trap_o)
);

// File: tb/test_exec_alu.sv
module test_exec_alu;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  op;
   logic [31:0] s, t;
   logic [15:0] imm;
   logic [4:0]  sh;
   logic [31:0] result;
   logic        trap;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   exec_alu i_exec_alu (
      .op_i       (op),
      .src_s_i    (s),
      .src_t_i    (t),
      .imm_i      (imm),
      .shamt_i    (sh),
      .result_o   (result),
      .ovf_trap_o (trap)
   );

   function automatic bit ovf32(longint w);
      return (w > 64'sd2147483647) || (w < -64'sd2147483648);
   endfunction

   // Reference model: returns {trap, result}
   function automatic logic [32:0] model(logic [4:0] o, logic [31:0] a, logic [31:0] b,
                                         logic [15:0] i, logic [4:0] c);
      longint sa = longint'($signed(a));
      longint sb = longint'($signed(b));
      logic [31:0] sx = {{16{i[15]}}, i};
      logic [31:0] zx = {16'h0, i};
      longint si = longint'($signed(sx));
      case (o)
         5'd0:  return {ovf32(sa + sb), a + b};
         5'd1:  return {1'b0, a + b};
         5'd2:  return {ovf32(sa - sb), a - b};
         5'd3:  return {1'b0, a - b};
         5'd4:  return {1'b0, a & b};
         5'd5:  return {1'b0, a | b};
         5'd6:  return {1'b0, a ^ b};
         5'd7:  return {1'b0, ~(a | b)};
         5'd8:  return {ovf32(sa + si), a + sx};
         5'd9:  return {1'b0, a + sx};
         5'd10: return {1'b0, a & zx};
         5'd11: return {1'b0, a | zx};
         5'd12: return {1'b0, a ^ zx};
         5'd13: return {1'b0, i, 16'h0};
         5'd14: return {1'b0, b << c};
         5'd15: return {1'b0, b >> c};
         5'd16: return {1'b0, 32'($signed(b) >>> c)};
         5'd17: return {1'b0, b << a[4:0]};
         5'd18: return {1'b0, b >> a[4:0]};
         5'd19: return {1'b0, 32'($signed(b) >>> a[4:0])};
         default: return 33'h0;
      endcase
   endfunction

   function automatic string req_of(logic [4:0] o);
      case (o)
         5'd0, 5'd2:               return "R1/R9";
         5'd1, 5'd3:               return "R2";
         5'd8, 5'd9:               return "R3";
         5'd4, 5'd5, 5'd6, 5'd7:   return "R4";
         5'd10, 5'd11, 5'd12:      return "R5";
         5'd13:                    return "R6";
         5'd14, 5'd15, 5'd16:      return "R7";
         5'd17, 5'd18, 5'd19:      return "R8";
         default:                  return "R10";
      endcase
   endfunction

   task automatic apply(logic [4:0] o, logic [31:0] a, logic [31:0] b,
                        logic [15:0] i, logic [4:0] c, string tag);
      logic [32:0] exp;
      @(posedge clk);
      op = o; s = a; t = b; imm = i; sh = c;
      @(negedge clk);
      exp = model(o, a, b, i, c);
      n_vec++;
      if ({trap, result} !== exp) begin
         n_bad++;
         $display("FAIL %s op=%0d s=%h t=%h imm=%h sh=%0d: got trap=%b res=%h, exp trap=%b res=%h",
                  tag, o, a, b, i, c, trap, result, exp[32], exp[31:0]);
      end
   endtask

   localparam logic [31:0] VALS [8] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF,
                                       32'h7FFF_FFFF, 32'h8000_0000, 32'h1234_5678,
                                       32'hFFFF_8001, 32'h0000_FFFF};
   localparam logic [15:0] IMMS [6] = '{16'h0000, 16'h0001, 16'h7FFF,
                                       16'h8000, 16'hFFFF, 16'h1234};

   initial begin
      op = 5'd0; s = '0; t = '0; imm = '0; sh = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // Idle state: opcode 0 with zero operands (R1)
      apply(5'd0, 32'h0, 32'h0, 16'h0, 5'd0, "R1");

      // Directed corners
      apply(5'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, "R1/R9");        // positive overflow
      apply(5'd2, 32'h8000_0000, 32'h1, 16'h0, 5'd0, "R1/R9");        // negative overflow
      apply(5'd1, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, "R2");           // no trap
      apply(5'd3, 32'h8000_0000, 32'h1, 16'h0, 5'd0, "R2");
      apply(5'd8, 32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd0, "R3");        // trap
      apply(5'd9, 32'h0000_0005, 32'h0, 16'hFFFF, 5'd0, "R3");        // 5 + (-1)
      apply(5'd11, 32'h0, 32'h0, 16'h8000, 5'd0, "R5");               // zero-extended
      apply(5'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hABCD, 5'd7, "R6");
      apply(5'd16, 32'h0, 32'h8000_0000, 16'h0, 5'd31, "R7");         // all ones
      apply(5'd25, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd3, "R10");

      // Sweep: every opcode x corner operands x immediates
      for (int o = 0; o < 32; o++)
         for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
               for (int k = 0; k < 6; k++)
                  apply(5'(o), VALS[a], VALS[b], IMMS[k], 5'((a * 7 + b * 3 + k * 5) % 32),
                        req_of(5'(o)));

      // Every shift count, constant and variable; S high bits set for variable (R7, R8)
      for (int o = 14; o < 20; o++)
         for (int c = 0; c < 32; c++)
            for (int b = 0; b < 8; b++)
               apply(5'(o), 32'hDEAD_BE00 | 32'(c), VALS[b], 16'h0, 5'(c), req_of(5'(o)));

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hang, exp completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule